// File: doc/BRIEF.md
# Upper-Block Boundary Write Guard

This block sits beside a 512-byte nonvolatile array and judges every prospective write. For the target byte address it drives an allow flag, which is combinational in that address and in the protect input. It also holds a mirror of the array's top byte. That byte stores a boundary pointer and a flag that enables protection when it is cleared.

While protection is in force, every address from the boundary up to the last location is refused. The boundary is set in 8-byte steps inside the upper 256-byte half. Protection is in force only when the external protect input is high and the pointer's flag bit reads 0. When the protect input is low, the top location is an ordinary byte.

The surrounding write engine raises a request together with the address and the data byte. The guard returns the allow decision and a commit strobe. When a committed write lands on the top location, the mirror loads the new byte in the same clock edge that the array does.

The guard judges one address at a time. It does not know about row wrapping. A multi-byte burst that starts below the boundary is therefore allowed until its address reaches the boundary, and refused from there on.

Top module: `blkWriteGuard`

## Requirements
- R1: After reset the pointer mirror holds FFh. Protection is therefore off, and every address is allowed even while the protect input is high.
- R2: Protection is in force only when protPin is 1 and bit 2 of the pointer is 0. If either condition fails, every address is allowed.
- R3: While protection is in force, any address at or above the boundary, up to and including 1FFh, is refused. Any address below the boundary is allowed.
- R4: Addresses 000h to 0FFh (address bit 8 = 0) are always allowed.
- R5: The boundary equals 100h + 8 × pointer[7:3]. Pointer bits 1:0 do not affect the boundary.
- R6: A committed write to 1FFh loads wrData into the pointer at that clock edge. The decision in that same cycle still uses the old pointer, and the new value governs from the next cycle on.
- R7: A refused write to 1FFh leaves the pointer unchanged.
- R8: wrCommit is 1 exactly when wrReq is 1 and the address is allowed. Without wrReq the pointer never changes.
- R9: protActive reports whether protection is in force (R2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| protPin | input | 1 | External protect enable, active high |
| wrReq | input | 1 | Write request from the write engine |
| wrAddr | input | 9 | Target byte address |
| wrData | input | 8 | Byte to be written |
| wrAllow | output | 1 | Target address may be written |
| wrCommit | output | 1 | Write accepted this cycle |
| protActive | output | 1 | Protection currently in force |

## Verification
Two functions can fall in the same cycle: judging a write to 1FFh, and reloading the pointer from that same write. The bench provokes this case by holding protPin high while the pointer flag is 1 and writing 00h to 1FFh. That write must be allowed and committed under the old pointer. From the very next cycle, 1FFh and 100h must read as refused. A second case writes FFh to 1FFh while protection is in force. It must be refused, and the boundary must be unchanged afterwards.

// File: rtl/guardPkg.sv
package guardPkg;

  // strobes from control to datapath
  typedef struct packed {
    logic ptrLoad;
    logic commit;
  } guardStrobeT;

endpackage

// File: rtl/guardDatapath.sv
module guardDatapath
  import guardPkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int ROW_BITS = 3,
  parameter int FLAG_BIT = 2,
  parameter logic [ADDR_W-2:0] PTR_RESET = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStrobeT       strb,
  input  logic              protPin,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-2:0] wrData,
  output logic              wrAllow,
  output logic              protActive,
  output logic [ADDR_W-2:0] ptrVal
);
  localparam int DATA_W = ADDR_W - 1;
  localparam int STEP_W = DATA_W - ROW_BITS;

  logic [DATA_W-1:0] ptrQ;
  logic [ADDR_W-1:0] boundary;
  logic              aboveBound;

  always_ff @(posedge clk) begin
    if (!rstN)             ptrQ <= PTR_RESET;
    else if (strb.ptrLoad) ptrQ <= wrData;
  end

  // lower bound lies in the upper half, row aligned
  assign boundary   = {1'b1, ptrQ[DATA_W-1 -: STEP_W], {ROW_BITS{1'b0}}};
  assign protActive = protPin && !ptrQ[FLAG_BIT];
  assign aboveBound = (wrAddr >= boundary);
  assign wrAllow    = !(protActive && aboveBound);
  assign ptrVal     = ptrQ;

  // R6: pointer follows the committed byte one edge later
  a_r6_ptr_follow: assert property (@(posedge clk) disable iff (!rstN)
    strb.ptrLoad |=> ptrVal == $past(wrData));

  // R4: lower half never refused
  a_r4_low_open: assert property (@(posedge clk) disable iff (!rstN)
    !wrAddr[ADDR_W-1] |-> wrAllow);

endmodule

// File: rtl/guardControl.sv
module guardControl
  import guardPkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrAllow,
  output guardStrobeT       strb
);
  localparam logic [ADDR_W-1:0] PTR_ADDR = '1;

  always_comb begin
    strb.commit  = wrReq && wrAllow;
    strb.ptrLoad = strb.commit && (wrAddr == PTR_ADDR);
  end

  // R8: no strobe without a request
  a_r8_no_req_no_load: assert property (@(posedge clk) disable iff (!rstN)
    !wrReq |-> !strb.ptrLoad && !strb.commit);

endmodule

// File: rtl/blkWriteGuard.sv
module blkWriteGuard
  import guardPkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int ROW_BITS = 3,
  parameter int FLAG_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              protPin,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-2:0] wrData,
  output logic              wrAllow,
  output logic              wrCommit,
  output logic              protActive
);
  localparam int DATA_W = ADDR_W - 1;

  guardStrobeT       strb;
  logic [DATA_W-1:0] ptrVal;

  guardControl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .wrAddr(wrAddr),
    .wrAllow(wrAllow), .strb(strb)
  );

  guardDatapath #(
    .ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .FLAG_BIT(FLAG_BIT),
    .PTR_RESET({DATA_W{1'b1}})
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .protPin(protPin),
    .wrAddr(wrAddr), .wrData(wrData), .wrAllow(wrAllow),
    .protActive(protActive), .ptrVal(ptrVal)
  );

  assign wrCommit = strb.commit;

  // R7: refused request leaves pointer alone
  a_r7_refused_keeps_ptr: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && !wrAllow |=> $stable(ptrVal));

  // R8: idle cycles never alter pointer
  a_r8_idle_keeps_ptr: assert property (@(posedge clk) disable iff (!rstN)
    !wrReq |=> $stable(ptrVal));

  // R3: top location refused whenever protection is in force
  a_r3_top_refused: assert property (@(posedge clk) disable iff (!rstN)
    protPin && !ptrVal[FLAG_BIT] && (&wrAddr) |-> !wrAllow);

  // R2: protect input low opens everything
  a_r2_pin_low_open: assert property (@(posedge clk) disable iff (!rstN)
    !protPin |-> wrAllow && !protActive);

endmodule

// File: tb/blkWriteGuard_tb.sv
module blkWriteGuard_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       protPin = 1'b0;
  logic       wrReq = 1'b0;
  logic [8:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       wrAllow, wrCommit, protActive;
  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  blkWriteGuard dut_i (
    .clk(clk), .rstN(rstN), .protPin(protPin), .wrReq(wrReq),
    .wrAddr(wrAddr), .wrData(wrData), .wrAllow(wrAllow),
    .wrCommit(wrCommit), .protActive(protActive)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic pin, input logic req, input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    protPin = pin; wrReq = req; wrAddr = a; wrData = d;
    #1;
  endtask

  // one committed-or-refused write; request dropped at next negedge
  task automatic writeByte(input logic pin, input logic [8:0] a, input logic [7:0] d,
                           input logic expAllow, input string tag);
    drive(pin, 1'b1, a, d);
    chk({tag, " allow"}, wrAllow, expAllow);
    chk({tag, " commit"}, wrCommit, expAllow);
    drive(pin, 1'b0, a, d);
  endtask

  task automatic probe(input logic [8:0] a, input logic exp, input string tag);
    drive(protPin, 1'b0, a, 8'h00);
    chk(tag, wrAllow, exp);
  endtask

  task automatic tReset;
    drive(1'b1, 1'b0, 9'h1FF, 8'h00);
    chk("R1 reset protActive", protActive, 1'b0);
    chk("R1 reset 1FF allowed", wrAllow, 1'b1);
    probe(9'h100, 1'b1, "R1 reset 100 allowed");
    probe(9'h000, 1'b1, "R4 reset 000 allowed");
  endtask

  task automatic tProgram;
    // A0h: boundary 1A0h, flag 0
    writeByte(1'b0, 9'h1FF, 8'hA0, 1'b1, "R6 program ptr pin low");
    drive(1'b0, 1'b0, 9'h1FF, 8'h00);
    chk("R2 pin low 1FF ordinary", wrAllow, 1'b1);
    chk("R9 pin low inactive", protActive, 1'b0);
    drive(1'b1, 1'b0, 9'h1A0, 8'h00);
    chk("R9 active", protActive, 1'b1);
    chk("R3 1A0 refused", wrAllow, 1'b0);
    probe(9'h19F, 1'b1, "R3 19F allowed");
    probe(9'h1FF, 1'b0, "R3 1FF refused");
    probe(9'h0FF, 1'b1, "R4 0FF allowed");
    probe(9'h000, 1'b1, "R4 000 allowed");
  endtask

  task automatic tSweep;
    // burst crossing boundary: R3
    for (int a = 'h19D; a <= 'h1A2; a++) begin
      writeByte(1'b1, 9'(a), 8'h55, (a < 'h1A0), "R3 burst across boundary");
    end
  endtask

  task automatic tFlagOff;
    writeByte(1'b0, 9'h1FF, 8'hA4, 1'b1, "R6 program flag 1");
    drive(1'b1, 1'b0, 9'h1A0, 8'h00);
    chk("R2 flag 1 inactive", protActive, 1'b0);
    chk("R2 flag 1 1A0 allowed", wrAllow, 1'b1);
  endtask

  task automatic tLowBits;
    // 03h: boundary bits zero, flag 0, bits 1:0 set
    writeByte(1'b0, 9'h1FF, 8'h03, 1'b1, "R5 program 03");
    drive(1'b1, 1'b0, 9'h100, 8'h00);
    chk("R5 100 refused", wrAllow, 1'b0);
    probe(9'h101, 1'b0, "R5 101 refused");
    probe(9'h0FF, 1'b1, "R5 0FF allowed");
  endtask

  task automatic tRefused;
    writeByte(1'b1, 9'h1FF, 8'hFF, 1'b0, "R7 refused ptr write");
    drive(1'b1, 1'b0, 9'h100, 8'h00);
    chk("R7 still active", protActive, 1'b1);
    chk("R7 100 still refused", wrAllow, 1'b0);
    // no request, pin low, top address with FFh on data
    drive(1'b0, 1'b0, 9'h1FF, 8'hFF);
    chk("R8 no commit w/o request", wrCommit, 1'b0);
    drive(1'b0, 1'b0, 9'h1FF, 8'hFF);
    drive(1'b1, 1'b0, 9'h100, 8'h00);
    chk("R8 pointer untouched", protActive, 1'b1);
  endtask

  task automatic tSameCycle;
    writeByte(1'b0, 9'h1FF, 8'h04, 1'b1, "R6 program flag off");
    // pin high, flag 1: write 00h to 1FF judged by old pointer
    drive(1'b1, 1'b1, 9'h1FF, 8'h00);
    chk("R6 same cycle old ptr allow", wrAllow, 1'b1);
    chk("R6 same cycle commit", wrCommit, 1'b1);
    drive(1'b1, 1'b0, 9'h1FF, 8'h00);
    chk("R6 next cycle 1FF refused", wrAllow, 1'b0);
    chk("R9 next cycle active", protActive, 1'b1);
    probe(9'h100, 1'b0, "R6 next cycle 100 refused");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    tReset();
    tProgram();
    tSweep();
    tFlagOff();
    tLowBits();
    tRefused();
    tSameCycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #50000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule